// File: doc/BRIEF.md
# Serial Control Register Port

This block is the write-only programming port of a sampling front end. A host frames a 16-bit control word by pulling a load strobe low and clocking bits in on a shift clock. When the strobe returns high, the frame is accepted only if exactly sixteen bits were clocked and the word is not a test command. An accepted word is held in a latch in the serial domain.

The fact that a word has been latched reaches the sampling clock domain as a toggle. There it is synchronized, edge-detected and decoded, then written into one of eight 12-bit control registers. The write happens on a fixed sampling edge, five edges after the strobe rises.

Two of the control registers act on the sample path. One bit puts the block in standby, which forces the sample output to zero. A 2-bit field adds zero to three cycles of delay to the output samples. All registers are visible as a flat output bus for the rest of the chip.

Top module: `serial_ctrl_port`

## Requirements
- R1: Bits are captured on rising `ser_clk` edges only while `ld_strobe` is low. Edges while the strobe is high neither shift nor count. Frame bit 15 is sent first and is the test flag. Bits 14:12 are the register address. Bits 11:0 are the data, sent most significant bit first.
- R2: When `ld_strobe` rises, a frame whose bit count is not exactly 16 is discarded and leaves every control register unchanged. This covers both 15-bit and 17-bit frames.
- R3: A 16-bit frame with the test flag (bit 15) set is ignored and leaves every control register unchanged.
- R4: Take the first `samp_clk` rising edge after the `ld_strobe` rise, when it meets setup, as edge 1. The addressed register holds its old value after edge 4 and shows the new value after edge 5. The write is never later than edge 6.
- R5: An accepted frame writes its 12 data bits into register `addr` only, and all other registers keep their values. Register i appears on `cfg_regs[i*12 +: 12]`.
- R6: When register 0 bit 0 (standby) is 1, `samp_out` becomes all zeros from the next `samp_clk` edge on. When the bit is cleared, samples flow again.
- R7: Let d be register 1 bits 1:0. The value of `samp_out` after `samp_clk` edge n equals the `samp_in` value sampled at edge n-d. This holds for d = 0, 1, 2 and 3.
- R8: While `rst` is high, every control register and `samp_out` are cleared, and the serial shift state and latch are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| samp_clk | input | 1 | Sampling clock; clocks the control registers and the sample path |
| rst | input | 1 | Active-high reset: synchronous in the sampling domain, asynchronous in the serial domain |
| ser_clk | input | 1 | Serial shift clock, rising-edge sampling |
| ld_strobe | input | 1 | Frame strobe: low while a frame is shifted, rising edge latches it |
| ser_din | input | 1 | Serial data, most significant bit first |
| samp_in | input | SAMP_W (10) | Incoming digital sample word |
| samp_out | output | SAMP_W (10) | Delayed sample word, zero in standby |
| cfg_regs | output | 96 | All eight 12-bit control registers, register i at bits i*12 +: 12 |

## Verification
The bench aims each control write so that its strobe rises just after a sampling edge. It then checks the register before and after the fifth edge. A design with one synchronizer stage too few, or too many, fails that timing exactly.

Frames of 15 and 17 bits and a frame with the test flag set are each followed by a full register compare. A design that latched on any strobe, or ignored the flag, would overwrite a register. Stray shift clocks while the strobe is high come just before a valid frame. A design that counted them would drop that frame.

The sample path is scored with each delay setting and with standby. An off-by-one tap selection or a standby gate that leaks shows up as a sample mismatch.

// File: rtl/serial_ctrl_pkg.sv
package serial_ctrl_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 12;
  localparam int FRAME_W = 1 + ADDR_W + DATA_W;
  localparam int NREG    = 1 << ADDR_W;
  localparam int REG_PWR = 0;
  localparam int REG_DLY = 1;
  localparam int STBY_BIT = 0;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } ctrl_word_t;
endpackage

// File: rtl/scp_shifter.sv
module scp_shifter
  import serial_ctrl_pkg::*;
(
  input  logic       ser_clk,
  input  logic       ld_strobe,
  input  logic       ser_din,
  input  logic       rst,
  output ctrl_word_t word_q,
  output logic       tog_q
);
  localparam int CNT_W = $clog2(FRAME_W + 2);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic               epoch;
  logic               ack;
  logic               frame_ok;

  // shift path; a new frame restarts the count on its first clock
  always_ff @(posedge ser_clk or posedge rst) begin
    if (rst) begin
      shreg <= '0;
      cnt   <= '0;
      ack   <= 1'b0;
    end else if (!ld_strobe) begin
      shreg <= {shreg[FRAME_W-2:0], ser_din};
      ack   <= epoch;
      if (ack != epoch)
        cnt <= CNT_W'(1);
      else if (cnt <= CNT_W'(FRAME_W))
        cnt <= cnt + 1'b1;
    end
  end

  assign frame_ok = (ack == epoch) && (cnt == CNT_W'(FRAME_W)) && !shreg[FRAME_W-1];

  // parallel latch on strobe rise
  always_ff @(posedge ld_strobe or posedge rst) begin
    if (rst) begin
      word_q <= '0;
      tog_q  <= 1'b0;
      epoch  <= 1'b0;
    end else begin
      epoch <= ~epoch;
      if (frame_ok) begin
        word_q <= ctrl_word_t'(shreg[FRAME_W-2:0]);
        tog_q  <= ~tog_q;
      end
    end
  end
endmodule

// File: rtl/scp_apply.sv
module scp_apply
  import serial_ctrl_pkg::*;
(
  input  logic                     samp_clk,
  input  logic                     rst,
  input  logic                     tog_in,
  input  ctrl_word_t               word_in,
  output logic [NREG*DATA_W-1:0]   regs_q,
  output logic                     wr_q
);
  logic              m1, m2, m3;
  logic              pulse_q;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  always_ff @(posedge samp_clk) begin
    if (rst) begin
      m1      <= 1'b0;
      m2      <= 1'b0;
      m3      <= 1'b0;
      pulse_q <= 1'b0;
      wr_q    <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      m1      <= tog_in;
      m2      <= m1;
      m3      <= m2;
      pulse_q <= m2 ^ m3;
      wr_q    <= pulse_q;
      if (pulse_q) begin
        wr_addr <= word_in.addr;
        wr_data <= word_in.data;
      end
    end
  end

  always_ff @(posedge samp_clk) begin
    if (rst) begin
      regs_q <= '0;
    end else if (wr_q) begin
      for (int i = 0; i < NREG; i++)
        if (wr_addr == ADDR_W'(i))
          regs_q[i*DATA_W +: DATA_W] <= wr_data;
    end
  end
endmodule

// File: rtl/scp_outpath.sv
module scp_outpath #(
  parameter int SAMP_W = 10,
  parameter int DLY_W  = 2
) (
  input  logic              samp_clk,
  input  logic              rst,
  input  logic              standby,
  input  logic [DLY_W-1:0]  dly,
  input  logic [SAMP_W-1:0] din,
  output logic [SAMP_W-1:0] dout
);
  localparam int MAXD = (1 << DLY_W) - 1;

  logic [MAXD-1:0][SAMP_W-1:0] pipe;
  logic [SAMP_W-1:0]           sel;

  always_ff @(posedge samp_clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= din;
      for (int k = 1; k < MAXD; k++)
        pipe[k] <= pipe[k-1];
    end
  end

  always_comb begin
    if (dly == '0) sel = din;
    else           sel = pipe[dly - 1'b1];
  end

  always_ff @(posedge samp_clk) begin
    if (rst)          dout <= '0;
    else if (standby) dout <= '0;
    else              dout <= sel;
  end
endmodule

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port
  import serial_ctrl_pkg::*;
#(
  parameter int SAMP_W = 10,
  parameter int DLY_W  = 2
) (
  input  logic                   samp_clk,
  input  logic                   rst,
  input  logic                   ser_clk,
  input  logic                   ld_strobe,
  input  logic                   ser_din,
  input  logic [SAMP_W-1:0]      samp_in,
  output logic [SAMP_W-1:0]      samp_out,
  output logic [NREG*DATA_W-1:0] cfg_regs
);
  ctrl_word_t        word_q;
  logic              tog_q;
  logic              wr_q;
  logic              standby;
  logic [DLY_W-1:0]  dly;

  scp_shifter u_shift (
    .ser_clk   (ser_clk),
    .ld_strobe (ld_strobe),
    .ser_din   (ser_din),
    .rst       (rst),
    .word_q    (word_q),
    .tog_q     (tog_q)
  );

  scp_apply u_apply (
    .samp_clk (samp_clk),
    .rst      (rst),
    .tog_in   (tog_q),
    .word_in  (word_q),
    .regs_q   (cfg_regs),
    .wr_q     (wr_q)
  );

  assign standby = cfg_regs[REG_PWR*DATA_W + STBY_BIT];
  assign dly     = cfg_regs[REG_DLY*DATA_W +: DLY_W];

  scp_outpath #(.SAMP_W(SAMP_W), .DLY_W(DLY_W)) u_out (
    .samp_clk (samp_clk),
    .rst      (rst),
    .standby  (standby),
    .dly      (dly),
    .din      (samp_in),
    .dout     (samp_out)
  );
endmodule

// File: rtl/scp_checker.sv
module scp_checker
  import serial_ctrl_pkg::*;
#(
  parameter int SAMP_W = 10,
  parameter int DLY_W  = 2
) (
  input logic                   samp_clk,
  input logic                   rst,
  input logic [SAMP_W-1:0]      samp_in,
  input logic [SAMP_W-1:0]      samp_out,
  input logic [NREG*DATA_W-1:0] cfg_regs,
  input logic                   standby,
  input logic [DLY_W-1:0]       dly,
  input logic                   wr_q
);
  AST_STANDBY_ZERO: assert property (@(posedge samp_clk) disable iff (rst)
    standby |=> (samp_out == '0)); // R6

  AST_DIRECT_PASS: assert property (@(posedge samp_clk) disable iff (rst)
    (dly == '0 && !standby) |=> (samp_out == $past(samp_in))); // R7

  AST_WRITE_ON_STROBE: assert property (@(posedge samp_clk) disable iff (rst)
    !$stable(cfg_regs) |-> $past(wr_q)); // R5

  AST_RESET_CLEAR: assert property (@(posedge samp_clk)
    $past(rst) |-> (cfg_regs == '0 && samp_out == '0)); // R8
endmodule

bind serial_ctrl_port scp_checker #(.SAMP_W(SAMP_W), .DLY_W(DLY_W)) u_chk (
  .samp_clk (samp_clk),
  .rst      (rst),
  .samp_in  (samp_in),
  .samp_out (samp_out),
  .cfg_regs (cfg_regs),
  .standby  (standby),
  .dly      (dly),
  .wr_q     (wr_q)
);

// File: tb/serial_ctrl_port_bench.sv
module serial_ctrl_port_bench;
  localparam int SAMP_W = 10;
  localparam int DW = 12;
  localparam int NR = 8;

  logic samp_clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0;
  logic ld_strobe = 1'b1;
  logic ser_din = 1'b0;
  logic [SAMP_W-1:0] samp_in = '0;
  logic [SAMP_W-1:0] samp_out;
  logic [NR*DW-1:0] cfg_regs;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [NR];
  logic [SAMP_W-1:0] exp_q [$];
  int  cur_d = 0;
  bit  stream_on = 0;
  bit  stby_exp = 0;
  bit  finished = 0;

  always #10 samp_clk = ~samp_clk;

  serial_ctrl_port #(.SAMP_W(SAMP_W), .DLY_W(2)) u_serial_ctrl_port (
    .samp_clk (samp_clk), .rst (rst), .ser_clk (ser_clk),
    .ld_strobe (ld_strobe), .ser_din (ser_din), .samp_in (samp_in),
    .samp_out (samp_out), .cfg_regs (cfg_regs)
  );

  function automatic logic [15:0] mk(input logic t, input logic [2:0] a, input logic [11:0] d);
    return {t, a, d};
  endfunction

  task automatic check_regs(input string tag);
    checks++;
    for (int i = 0; i < NR; i++) begin
      if (cfg_regs[i*DW +: DW] !== model[i]) begin
        errors++;
        $display("FAIL %s reg%0d actual %h expected %h", tag, i, cfg_regs[i*DW +: DW], model[i]);
        break;
      end
    end
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n);
    ld_strobe = 1'b0;
    #7;
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = bits[i];
      #10 ser_clk = 1'b1;
      #10 ser_clk = 1'b0;
    end
    #5;
  endtask

  // strobe rises 5 ns after a sampling edge; that edge's successor is edge 1
  task automatic raise_aligned();
    @(posedge samp_clk);
    #5 ld_strobe = 1'b1;
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [11:0] d, input string tag);
    shift_bits({16'h0, mk(1'b0, a, d)}, 16);
    raise_aligned();
    repeat (6) @(posedge samp_clk);
    #2;
    model[a] = d;
    check_regs(tag);
  endtask

  task automatic write_timed(input logic [2:0] a, input logic [11:0] d);
    shift_bits({16'h0, mk(1'b0, a, d)}, 16);
    raise_aligned();
    for (int e = 1; e <= 5; e++) begin
      @(posedge samp_clk);
      #2;
      if (e == 4) check_regs("R4 old value through edge 4");
      if (e == 5) begin
        model[a] = d;
        check_regs("R4 new value after edge 5");
      end
    end
  endtask

  task automatic bad_frame(input logic [31:0] bits, input int n, input string tag);
    shift_bits(bits, n);
    raise_aligned();
    repeat (8) @(posedge samp_clk);
    #2;
    check_regs(tag);
  endtask

  // driver: applies samples and queues them for the monitor
  task automatic drive_stream(input int n, input logic [SAMP_W-1:0] seed);
    logic [SAMP_W-1:0] v;
    v = seed;
    exp_q.delete();
    @(negedge samp_clk);
    stream_on = 1;
    for (int i = 0; i < n; i++) begin
      v = {v[SAMP_W-2:0], v[SAMP_W-1] ^ v[6]} ^ SAMP_W'(i);
      samp_in = v;
      exp_q.push_back(v);
      if (i != n - 1) @(negedge samp_clk);
    end
    @(posedge samp_clk);
    #8;
    stream_on = 0;
    exp_q.delete();
  endtask

  // monitor: pops queued samples as the design emits them
  initial begin
    forever begin
      @(posedge samp_clk);
      #5;
      if (stream_on && exp_q.size() > cur_d) begin
        logic [SAMP_W-1:0] e;
        e = exp_q.pop_front();
        if (stby_exp) e = '0;
        checks++;
        if (samp_out !== e) begin
          errors++;
          $display("FAIL %s d=%0d actual %h expected %h",
                   stby_exp ? "R6" : "R7", cur_d, samp_out, e);
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (5) @(posedge samp_clk);
    @(negedge samp_clk);
    rst = 1'b0;
    #2;
    check_regs("R8 registers after reset");
    checks++;
    if (samp_out !== '0) begin
      errors++;
      $display("FAIL R8 samp_out actual %h expected 0", samp_out);
    end

    write_timed(3'd2, 12'hABC);
    write_reg(3'd3, 12'h5A1, "R5 write reg3");
    write_reg(3'd7, 12'hF0F, "R5 write reg7");
    write_reg(3'd2, 12'h123, "R5 overwrite reg2");
    write_timed(3'd5, 12'h9C3);

    bad_frame({16'h0, mk(1'b0, 3'd4, 12'h777)} >> 1, 15, "R2 15-bit frame");
    bad_frame({15'h0, 1'b0, mk(1'b0, 3'd4, 12'h777)}, 17, "R2 17-bit frame");
    bad_frame({16'h0, mk(1'b1, 3'd6, 12'h0AA)}, 16, "R3 test flag frame");

    // R1: stray shift clocks while strobe high must not spoil the next frame
    for (int i = 0; i < 3; i++) begin
      ser_din = 1'b1;
      #10 ser_clk = 1'b1;
      #10 ser_clk = 1'b0;
    end
    write_reg(3'd6, 12'hC35, "R1 frame after stray clocks");
    write_reg(3'd4, 12'h801, "R1 msb first order");

    for (int d = 0; d < 4; d++) begin
      write_reg(3'd1, 12'(d), "R7 set delay");
      cur_d = d;
      drive_stream(20, SAMP_W'(37 + d));
    end

    write_reg(3'd0, 12'h001, "R6 set standby");
    stby_exp = 1;
    drive_stream(12, 10'h155);
    stby_exp = 0;
    write_reg(3'd0, 12'h000, "R6 clear standby");
    drive_stream(12, 10'h0F3);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule